// File: doc/BRIEF.md
# Tag-Matching Reservation Station Pool

This block holds a small set of reservation stations in front of one functional unit of a dynamically scheduled floating-point pipeline. The issue stage hands it an operation code and two source operands. Each operand arrives in one of two forms. A zero tag means the operand is already a value. A nonzero tag names the station or load buffer that will produce the value later. The new instruction is placed in the lowest free station. The block returns that station's tag so the rename logic can record it as the producer of the destination register.

Every waiting station watches a shared result broadcast. When a broadcast tag matches a pending operand, the station copies the value and clears that tag. Each operand is filled on its own. A station whose two tags are both zero is ready. When the unit can take work, the lowest-indexed ready station is sent to it. The station keeps its tag reserved until the unit broadcasts that station's own result, and only then becomes free. A full indication tells issue to stall.

Top module: `rs_pool`

## Requirements
- R1: A synchronous reset frees every station. After reset, `full` is 0 and `disp_valid` is 0.
- R2: An issue is accepted when `iss_valid` is high and `full` is low. It goes into the lowest-indexed free station. The tag of station i is `TAG_BASE + i`, and `iss_tag` shows the tag the issue receives in that cycle.
- R3: `full` is high exactly when every station is busy. An issue presented while `full` is high is dropped and changes no station.
- R4: An operand issued with tag 0 is stored as a value. A station issued with both tags 0 is ready from the next cycle.
- R5: A broadcast (`bc_valid`, `bc_tag`, `bc_value`) is captured independently by every waiting operand whose nonzero tag equals `bc_tag`. That tag becomes 0.
- R6: If an issued operand's nonzero tag equals the tag broadcast in the issue cycle, the broadcast value is stored at issue and the operand does not wait.
- R7: `disp_valid` is high only when `fu_free` is high and some station holds two zero tags and has not yet been sent. `disp_tag`, `disp_op`, `disp_vj` and `disp_vk` then describe that station.
- R8: When several stations are ready, the one with the lowest index is dispatched.
- R9: A station is dispatched once and stays busy until `bc_tag` equals its own tag with `bc_valid` high. It is free from the following cycle.
- R10: A broadcast whose tag matches no pending operand and no dispatched station changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| iss_valid | input | 1 | Issue request |
| iss_op | input | OP_W | Operation code to store |
| iss_vj | input | DATA_W | First operand value (used when iss_qj is 0) |
| iss_qj | input | TAG_W | First operand producer tag, 0 = value ready |
| iss_vk | input | DATA_W | Second operand value (used when iss_qk is 0) |
| iss_qk | input | TAG_W | Second operand producer tag, 0 = value ready |
| full | output | 1 | All stations busy; issue must stall |
| iss_tag | output | TAG_W | Tag given to an issue accepted this cycle |
| bc_valid | input | 1 | Result broadcast present |
| bc_tag | input | TAG_W | Tag of the broadcasting producer |
| bc_value | input | DATA_W | Broadcast result value |
| fu_free | input | 1 | Functional unit can accept an operation |
| disp_valid | output | 1 | A station is dispatched this cycle |
| disp_tag | output | TAG_W | Tag of the dispatched station |
| disp_op | output | OP_W | Operation of the dispatched station |
| disp_vj | output | DATA_W | First operand value |
| disp_vk | output | DATA_W | Second operand value |

## Verification
The bench builds the pool with three stations, a 16-bit datapath and `TAG_BASE` of 4. With these values, three issues fill the pool and the stall and drop path is reached early. Station tags 4 to 6 do not overlap the load-buffer tags 1 to 3 that the bench broadcasts. A directed sequence covers capture at issue, reuse of a freed tag, and two stations becoming ready in the same cycle. A long random phase then mixes issue, dispatch and broadcast traffic against a reference model.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

    // Life cycle of one station
    typedef enum logic [1:0] {
        SLOT_FREE   = 2'd0,
        SLOT_WAIT   = 2'd1,
        SLOT_ISSUED = 2'd2
    } slot_phase_e;

endpackage

// File: rtl/rs_lowpick.sv
module rs_lowpick #(
    parameter int W = 4,
    localparam int IDX_W = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]     req,
    output logic [W-1:0]     gnt,
    output logic [IDX_W-1:0] idx,
    output logic             any
);

    // Walk from the top so the lowest requester is the last one written
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IDX_W'(i);
                any    = 1'b1;
            end
        end
    end

endmodule

// File: rtl/rs_slot.sv
module rs_slot
    import rs_pool_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 4,
    parameter int OP_W   = 4,
    parameter logic [TAG_W-1:0] MY_TAG = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alloc,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              launch,
    output logic              busy,
    output logic              ready,
    output logic [OP_W-1:0]   op_o,
    output logic [DATA_W-1:0] vj_o,
    output logic [DATA_W-1:0] vk_o
);

    typedef struct packed {
        slot_phase_e       phase;
        logic [OP_W-1:0]   op;
        logic [DATA_W-1:0] vj;
        logic [TAG_W-1:0]  qj;
        logic [DATA_W-1:0] vk;
        logic [TAG_W-1:0]  qk;
    } slot_t;

    slot_t s_d, s_q;
    logic  hit_j, hit_k, own_done;

    assign hit_j    = bc_valid && (s_q.qj != '0) && (bc_tag == s_q.qj);
    assign hit_k    = bc_valid && (s_q.qk != '0) && (bc_tag == s_q.qk);
    assign own_done = bc_valid && (bc_tag == MY_TAG);

    always_comb begin
        s_d = s_q;
        if (alloc) begin
            s_d.phase = SLOT_WAIT;
            s_d.op    = iss_op;
            if (iss_qj != '0 && bc_valid && bc_tag == iss_qj) begin
                s_d.vj = bc_value;
                s_d.qj = '0;
            end else begin
                s_d.vj = iss_vj;
                s_d.qj = iss_qj;
            end
            if (iss_qk != '0 && bc_valid && bc_tag == iss_qk) begin
                s_d.vk = bc_value;
                s_d.qk = '0;
            end else begin
                s_d.vk = iss_vk;
                s_d.qk = iss_qk;
            end
        end else begin
            case (s_q.phase)
                SLOT_WAIT: begin
                    if (hit_j) begin
                        s_d.vj = bc_value;
                        s_d.qj = '0;
                    end
                    if (hit_k) begin
                        s_d.vk = bc_value;
                        s_d.qk = '0;
                    end
                    if (launch) s_d.phase = SLOT_ISSUED;
                end
                SLOT_ISSUED: begin
                    if (own_done) s_d.phase = SLOT_FREE;
                end
                default: s_d.phase = SLOT_FREE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= s_d;
    end

    assign busy  = (s_q.phase != SLOT_FREE);
    assign ready = (s_q.phase == SLOT_WAIT) && (s_q.qj == '0) && (s_q.qk == '0);
    assign op_o  = s_q.op;
    assign vj_o  = s_q.vj;
    assign vk_o  = s_q.vk;

    // Only a free station may take a new issue
    assert_alloc_into_free_R3: assert property (@(posedge clk) disable iff (rst)
        alloc |-> (s_q.phase == SLOT_FREE));

    // A launch must find both operands present
    assert_launch_has_values_R7: assert property (@(posedge clk) disable iff (rst)
        launch |-> (s_q.phase == SLOT_WAIT && s_q.qj == '0 && s_q.qk == '0));

    // A matching broadcast fills the first operand by the next cycle
    assert_capture_fills_R5: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == SLOT_WAIT && !alloc && hit_j) |=> (s_q.qj == '0 && s_q.vj == $past(bc_value)));

    // A sent station stays reserved until its own result appears
    assert_hold_until_own_R9: assert property (@(posedge clk) disable iff (rst)
        (s_q.phase == SLOT_ISSUED && !own_done && !alloc) |=> (s_q.phase == SLOT_ISSUED));

endmodule

// File: rtl/rs_pool.sv
module rs_pool
    import rs_pool_pkg::*;
#(
    parameter int N_SLOTS  = 4,
    parameter int DATA_W   = 32,
    parameter int TAG_W    = 4,
    parameter int OP_W     = 4,
    parameter int TAG_BASE = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              iss_valid,
    input  logic [OP_W-1:0]   iss_op,
    input  logic [DATA_W-1:0] iss_vj,
    input  logic [TAG_W-1:0]  iss_qj,
    input  logic [DATA_W-1:0] iss_vk,
    input  logic [TAG_W-1:0]  iss_qk,
    output logic              full,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              bc_valid,
    input  logic [TAG_W-1:0]  bc_tag,
    input  logic [DATA_W-1:0] bc_value,
    input  logic              fu_free,
    output logic              disp_valid,
    output logic [TAG_W-1:0]  disp_tag,
    output logic [OP_W-1:0]   disp_op,
    output logic [DATA_W-1:0] disp_vj,
    output logic [DATA_W-1:0] disp_vk
);

    localparam int IDX_W = (N_SLOTS > 1) ? $clog2(N_SLOTS) : 1;

    logic [N_SLOTS-1:0] busy_vec, ready_vec;
    logic [N_SLOTS-1:0] free_gnt, ready_gnt;
    logic [N_SLOTS-1:0] alloc_vec, launch_vec;
    logic [IDX_W-1:0]   free_idx, ready_idx;
    logic               free_any, ready_any, accept;

    logic [OP_W-1:0]    op_arr [N_SLOTS];
    logic [DATA_W-1:0]  vj_arr [N_SLOTS];
    logic [DATA_W-1:0]  vk_arr [N_SLOTS];

    rs_lowpick #(.W(N_SLOTS)) u_free_pick (
        .req (~busy_vec),
        .gnt (free_gnt),
        .idx (free_idx),
        .any (free_any)
    );

    rs_lowpick #(.W(N_SLOTS)) u_ready_pick (
        .req (ready_vec),
        .gnt (ready_gnt),
        .idx (ready_idx),
        .any (ready_any)
    );

    assign full       = !free_any;
    assign accept     = iss_valid && free_any;
    assign alloc_vec  = accept ? free_gnt : '0;
    assign disp_valid = fu_free && ready_any;
    assign launch_vec = disp_valid ? ready_gnt : '0;
    assign iss_tag    = TAG_W'(TAG_BASE) + TAG_W'(free_idx);
    assign disp_tag   = TAG_W'(TAG_BASE) + TAG_W'(ready_idx);

    for (genvar g = 0; g < N_SLOTS; g++) begin : g_slot
        rs_slot #(
            .DATA_W (DATA_W),
            .TAG_W  (TAG_W),
            .OP_W   (OP_W),
            .MY_TAG (TAG_W'(TAG_BASE + g))
        ) u_slot (
            .clk      (clk),
            .rst      (rst),
            .alloc    (alloc_vec[g]),
            .iss_op   (iss_op),
            .iss_vj   (iss_vj),
            .iss_qj   (iss_qj),
            .iss_vk   (iss_vk),
            .iss_qk   (iss_qk),
            .bc_valid (bc_valid),
            .bc_tag   (bc_tag),
            .bc_value (bc_value),
            .launch   (launch_vec[g]),
            .busy     (busy_vec[g]),
            .ready    (ready_vec[g]),
            .op_o     (op_arr[g]),
            .vj_o     (vj_arr[g]),
            .vk_o     (vk_arr[g])
        );
    end

    // One-hot grant steers the winning station onto the dispatch port
    always_comb begin
        disp_op = '0;
        disp_vj = '0;
        disp_vk = '0;
        for (int i = 0; i < N_SLOTS; i++) begin
            if (ready_gnt[i]) begin
                disp_op = disp_op | op_arr[i];
                disp_vj = disp_vj | vj_arr[i];
                disp_vk = disp_vk | vk_arr[i];
            end
        end
    end

    // At most one station is claimed per cycle
    assert_single_alloc_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0(alloc_vec));

    // With no broadcast, nothing can free up, so a full pool stays full
    assert_full_persists_R3: assert property (@(posedge clk) disable iff (rst)
        (full && !bc_valid) |=> full);

    // No ready station below the one being dispatched
    assert_dispatch_lowest_R8: assert property (@(posedge clk) disable iff (rst)
        disp_valid |-> ((ready_vec & (launch_vec - 1'b1)) == '0));

    // A station leaves the ready set once launched
    assert_launch_once_R9: assert property (@(posedge clk) disable iff (rst)
        disp_valid |=> ((ready_vec & $past(launch_vec)) == '0));

endmodule

// File: tb/sim_rs_pool.sv
module sim_rs_pool;

    localparam int  N       = 3;
    localparam int  DW      = 16;
    localparam int  TW      = 4;
    localparam int  OW      = 3;
    localparam int  BASE    = 4;
    localparam time PERIOD  = 10;

    logic          clk = 1'b0;
    logic          rst;
    logic          iss_valid;
    logic [OW-1:0] iss_op;
    logic [DW-1:0] iss_vj, iss_vk;
    logic [TW-1:0] iss_qj, iss_qk;
    logic          full;
    logic [TW-1:0] iss_tag;
    logic          bc_valid;
    logic [TW-1:0] bc_tag;
    logic [DW-1:0] bc_value;
    logic          fu_free;
    logic          disp_valid;
    logic [TW-1:0] disp_tag;
    logic [OW-1:0] disp_op;
    logic [DW-1:0] disp_vj, disp_vk;

    int checks = 0;
    int fails  = 0;
    string cur_req = "R1";

    always #(PERIOD / 2) clk = ~clk;

    rs_pool #(.N_SLOTS(N), .DATA_W(DW), .TAG_W(TW), .OP_W(OW), .TAG_BASE(BASE)) u0 (
        .clk(clk), .rst(rst),
        .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_vj(iss_vj), .iss_qj(iss_qj), .iss_vk(iss_vk), .iss_qk(iss_qk),
        .full(full), .iss_tag(iss_tag),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value),
        .fu_free(fu_free),
        .disp_valid(disp_valid), .disp_tag(disp_tag), .disp_op(disp_op),
        .disp_vj(disp_vj), .disp_vk(disp_vk)
    );

    // Reference model: 0 free, 1 waiting for operands or dispatch, 2 sent
    int m_ph [N];
    int m_op [N];
    int m_vj [N];
    int m_qj [N];
    int m_vk [N];
    int m_qk [N];

    function automatic int lowest_free();
        for (int i = 0; i < N; i++) if (m_ph[i] == 0) return i;
        return -1;
    endfunction

    function automatic int lowest_ready();
        for (int i = 0; i < N; i++)
            if (m_ph[i] == 1 && m_qj[i] == 0 && m_qk[i] == 0) return i;
        return -1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < N; i++) m_ph[i] = 0;
        end else begin
            int a;
            int d;
            a = iss_valid ? lowest_free() : -1;
            d = fu_free ? lowest_ready() : -1;
            for (int i = 0; i < N; i++) begin
                if (m_ph[i] == 2 && bc_valid && int'(bc_tag) == BASE + i) m_ph[i] = 0;
                else if (m_ph[i] == 1) begin
                    if (m_qj[i] != 0 && bc_valid && int'(bc_tag) == m_qj[i]) begin
                        m_vj[i] = int'(bc_value); m_qj[i] = 0;
                    end
                    if (m_qk[i] != 0 && bc_valid && int'(bc_tag) == m_qk[i]) begin
                        m_vk[i] = int'(bc_value); m_qk[i] = 0;
                    end
                    if (i == d) m_ph[i] = 2;
                end
            end
            if (a >= 0) begin
                m_ph[a] = 1;
                m_op[a] = int'(iss_op);
                m_vj[a] = int'(iss_vj); m_qj[a] = int'(iss_qj);
                m_vk[a] = int'(iss_vk); m_qk[a] = int'(iss_qk);
                if (m_qj[a] != 0 && bc_valid && int'(bc_tag) == m_qj[a]) begin
                    m_vj[a] = int'(bc_value); m_qj[a] = 0;
                end
                if (m_qk[a] != 0 && bc_valid && int'(bc_tag) == m_qk[a]) begin
                    m_vk[a] = int'(bc_value); m_qk[a] = 0;
                end
            end
        end
    end

    task automatic compare();
        int  f, r;
        bit  e_full, e_dv, bad;
        f      = lowest_free();
        r      = fu_free ? lowest_ready() : -1;
        e_full = (f < 0);
        e_dv   = (r >= 0);
        bad    = (full !== e_full) || (disp_valid !== e_dv);
        if (!e_full && int'(iss_tag) != BASE + f) bad = 1;
        if (e_dv && (int'(disp_tag) != BASE + r || int'(disp_op) != m_op[r] ||
                     int'(disp_vj) != m_vj[r] || int'(disp_vk) != m_vk[r])) bad = 1;
        checks++;
        if (bad) begin
            fails++;
            $display("FAIL %s cycle compare: full=%0d dv=%0d tag=%0d op=%0d vj=%0d vk=%0d itag=%0d expected full=%0d dv=%0d tag=%0d op=%0d vj=%0d vk=%0d itag=%0d",
                     cur_req, full, disp_valid, disp_tag, disp_op, disp_vj, disp_vk, iss_tag,
                     e_full, e_dv, e_dv ? BASE + r : 0, e_dv ? m_op[r] : 0,
                     e_dv ? m_vj[r] : 0, e_dv ? m_vk[r] : 0, e_full ? 0 : BASE + f);
        end
    endtask

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input bit iv, input int o, input int vj, input int qj,
                         input int vk, input int qk, input bit bv, input int bt,
                         input int bval, input bit fu);
        iss_valid = iv;
        iss_op    = OW'(o);
        iss_vj    = DW'(vj);
        iss_qj    = TW'(qj);
        iss_vk    = DW'(vk);
        iss_qk    = TW'(qk);
        bc_valid  = bv;
        bc_tag    = TW'(bt);
        bc_value  = DW'(bval);
        fu_free   = fu;
        #1 compare();
    endtask

    task automatic adv();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        rst = 1'b1;
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk); @(negedge clk);
        rst = 1'b0;
        #1;
        chk("R1", "full after reset", int'(full), 0);
        chk("R1", "disp_valid after reset", int'(disp_valid), 0);

        cur_req = "R2";
        drive(1, 1, 10, 0, 0, 1, 0, 0, 0, 1);      // station 0 waits on load tag 1
        chk("R2", "first issue tag", int'(iss_tag), 4);
        adv();
        drive(1, 2, 20, 0, 21, 0, 0, 0, 0, 1);     // station 1 ready at once
        chk("R2", "second issue tag", int'(iss_tag), 5);
        chk("R7", "no dispatch while tag pending", int'(disp_valid), 0);
        adv();
        cur_req = "R4";
        drive(1, 3, 0, 2, 30, 0, 1, 1, 77, 1);     // station 2; load 1 fills station 0
        chk("R2", "third issue tag", int'(iss_tag), 6);
        chk("R4", "ready issue dispatched", int'(disp_tag), 5);
        chk("R4", "ready issue vk", int'(disp_vk), 21);
        adv();
        cur_req = "R3";
        chk("R3", "full with all busy", int'(full), 1);
        drive(1, 7, 1, 0, 1, 0, 0, 0, 0, 1);       // dropped issue
        chk("R5", "captured operand dispatched tag", int'(disp_tag), 4);
        chk("R5", "captured operand value", int'(disp_vk), 77);
        adv();
        cur_req = "R10";
        drive(1, 7, 1, 0, 1, 0, 1, 3, 5, 0);       // unrelated tag, dropped issue
        chk("R3", "still full", int'(full), 1);
        adv();
        drive(0, 0, 0, 0, 0, 0, 1, 5, 99, 1);      // station 1 result
        chk("R10", "unrelated broadcast leaves station 2 waiting", int'(disp_valid), 0);
        adv();
        cur_req = "R6";
        drive(1, 4, 0, 2, 40, 0, 1, 2, 55, 0);     // capture at issue, station 2 also fills
        chk("R9", "freed station accepts issue", int'(full), 0);
        chk("R9", "freed tag reused", int'(iss_tag), 5);
        adv();
        cur_req = "R7";
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        chk("R7", "unit busy holds dispatch", int'(disp_valid), 0);
        adv();
        cur_req = "R8";
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R8", "lowest ready station first", int'(disp_tag), 5);
        chk("R6", "value captured at issue", int'(disp_vj), 55);
        adv();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R8", "next ready station", int'(disp_tag), 6);
        chk("R5", "station 2 captured vj", int'(disp_vj), 55);
        adv();
        cur_req = "R9";
        drive(0, 0, 0, 0, 0, 0, 1, 4, 0, 1);
        chk("R9", "no second dispatch", int'(disp_valid), 0);
        adv();
        drive(0, 0, 0, 0, 0, 0, 1, 5, 0, 1);
        adv();
        drive(0, 0, 0, 0, 0, 0, 1, 6, 0, 1);
        adv();
        drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 1);
        chk("R9", "all freed by own broadcasts", int'(full), 0);
        chk("R2", "empty pool gives lowest tag", int'(iss_tag), 4);

        cur_req = "mixed";
        for (int n = 0; n < 4000; n++) begin
            int  pick, bt;
            bit  bv;
            pick = int'($urandom_range(N - 1));
            bv   = ($urandom_range(3) != 0);
            if (m_ph[pick] == 2) bt = BASE + pick;
            else                 bt = int'($urandom_range(3, 1));
            drive($urandom_range(1) == 1, int'($urandom_range(7)),
                  int'($urandom_range(65535)), int'($urandom_range(3)),
                  int'($urandom_range(65535)), int'($urandom_range(3)),
                  bv, bt, int'($urandom_range(65535)), $urandom_range(2) != 0);
            adv();
        end

        summary();
        $finish;
    end

endmodule